// File: doc/BRIEF.md
# Two-Bank DRAM Timing Guard

This block watches the command pins between a memory controller's command issuer and a synchronous DRAM that has two internal banks. Each cycle it decodes the chip-select, row-strobe, column-strobe and write-enable levels, together with the bank-select bit and the precharge-select address line, into one of four commands: activate, read, write or precharge. It keeps a small state machine and a set of cycle counters for each bank.

From that state it raises one ready flag per bank for each command class, so the issuer can tell in advance whether a command would be legal in the current cycle. Any command that would break a timing rule is reported on a one-cycle violation strobe carrying a rule code, and the tracked bank state is left as it was. A bank left open too long is reported on its own overdue pulse. An early warning flag rises a programmable number of cycles before that limit.

All minimum and maximum spacings are runtime inputs in clock cycles. Software computes each one by dividing the nanosecond figure by the clock period and rounding up.

Top module: `dram_bank_guard`

## Requirements
- R1: Commands are decoded only while `csN` is low, from {`rasN`,`casN`,`weN`}: 011 is activate, 101 is read, 100 is write, and 010 is precharge only when `preSel` is 1. With `csN` high, or with 010 and `preSel` at 0, nothing happens: no violation is reported and no bank state changes.
- R2: A read or write to bank b is legal only when b is active and at least `cfgRcd` cycles have passed since its activate. `rwReady[b]` shows this condition. A read or write to a bank that is not active reports code 3. One issued too early reports code 4.
- R3: An activate to one bank must come at least `cfgRrd` cycles after the last accepted activate to the other bank, otherwise it reports code 2. `actReady[b]` is high only when bank b is idle and this spacing is met.
- R4: An activate to a bank that is active, or still precharging, reports code 1.
- R5: A precharge is legal only on an active bank at least `cfgRasMin` cycles after its activate. `preReady[b]` shows this condition. A precharge to a bank that is not active reports code 5. One issued too early reports code 6.
- R6: If bank b is still active, with no precharge accepted, in the cycle exactly `cfgRasMax` cycles after its activate, `rasOverdue[b]` is high for exactly the following cycle.
- R7: `rasWarn[b]` is high while bank b is active and the cycles since its activate plus `cfgWarnLead` are at least `cfgRasMax`.
- R8: After an accepted precharge, bank b reads as idle (`bankIdle[b]`) and can be activated only once at least `cfgRp` cycles have passed. A bank is never both idle and active.
- R9: A rule violation pulses `violValid` for the one cycle after the offending command, with its code on `violCode`. The command has no effect on bank state.
- R10: After reset both banks are idle, neither is active, `violValid` and the warning and overdue flags are low, and `actReady` is high for both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankSel | input | 1 | Bank addressed by the command |
| preSel | input | 1 | Precharge-select address line (line 8) |
| cfgRcd | input | CNT_W | Activate to read/write spacing, cycles |
| cfgRrd | input | CNT_W | Activate to activate spacing across banks, cycles |
| cfgRasMin | input | CNT_W | Minimum open time before precharge, cycles |
| cfgRasMax | input | CNT_W | Maximum open time, cycles |
| cfgRp | input | CNT_W | Precharge recovery time, cycles |
| cfgWarnLead | input | CNT_W | Warning lead ahead of the open-time limit, cycles |
| actReady | output | 2 | Activate to bank b would be legal now |
| rwReady | output | 2 | Read/write to bank b would be legal now |
| preReady | output | 2 | Precharge to bank b would be legal now |
| bankIdle | output | 2 | Bank b is idle |
| bankActive | output | 2 | Bank b has an open row |
| rasWarn | output | 2 | Bank b nears its open-time limit |
| rasOverdue | output | 2 | Bank b passed its open-time limit (pulse) |
| violValid | output | 1 | A rule was broken by the previous command |
| violCode | output | 3 | Rule code of that violation |

## Verification
The legality checks are driven by a run of back-to-back commands with fixed spacings. Each command in the run lands on one side of a single rule, so a legal read, an early read and a read to a closed bank each produce a different code. Two inputs that would act as an activate or precharge if fully decoded, a deselected one and one with the precharge line low, separate a correct decoder from one that ignores chip select or that address line. A second run holds one bank open past its limit and then precharges it, and compares every ready, warning, idle and overdue flag cycle by cycle against the programmed counts. This exposes off-by-one errors at each threshold.

// File: rtl/dram_guard_pkg.sv
package dram_guard_pkg;
  localparam int NUM_BANKS = 2;
  localparam int BANK_W    = 1;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECHG = 2'd2
  } bankState_e;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    VIO_NONE       = 3'd0,
    VIO_ACT_BUSY   = 3'd1,
    VIO_ACT_RRD    = 3'd2,
    VIO_RW_CLOSED  = 3'd3,
    VIO_RW_RCD     = 3'd4,
    VIO_PRE_CLOSED = 3'd5,
    VIO_PRE_RASMIN = 3'd6
  } violCode_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] actStart;
    logic [NUM_BANKS-1:0] preStart;
  } bankStrobe_t;

  // threshold results from the datapath back to control
  typedef struct packed {
    logic [NUM_BANKS-1:0] rcdMet;
    logic [NUM_BANKS-1:0] rasMinMet;
    logic [NUM_BANKS-1:0] rasMaxNow;
    logic [NUM_BANKS-1:0] warnNow;
    logic [NUM_BANKS-1:0] rpMet;
    logic [NUM_BANKS-1:0] rrdMet;
  } timingFlags_t;
endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_guard_pkg::*;
(
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic preSel,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = preSel ? CMD_PRE : CMD_NOP;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_guard_timers.sv
module dram_guard_timers
  import dram_guard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobe_t      strobe,
  input  logic [CNT_W-1:0] cfgRcd,
  input  logic [CNT_W-1:0] cfgRrd,
  input  logic [CNT_W-1:0] cfgRasMin,
  input  logic [CNT_W-1:0] cfgRasMax,
  input  logic [CNT_W-1:0] cfgRp,
  input  logic [CNT_W-1:0] cfgWarnLead,
  output timingFlags_t     flags
);
  localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] AGE_SAT = {CNT_W{1'b1}};

  logic [NUM_BANKS-1:0] rcdMet, rasMinMet, rasMaxNow, warnNow, rpMet, rrdMet;

  // shared activate spacing tracker
  logic [CNT_W-1:0] lastActAge;
  logic             anyAct;
  logic [BANK_W-1:0] lastActBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastActAge  <= '0;
      anyAct      <= 1'b0;
      lastActBank <= '0;
    end else if (|strobe.actStart) begin
      lastActAge  <= AGE_ONE;
      anyAct      <= 1'b1;
      lastActBank <= BANK_W'(strobe.actStart[1]);
    end else if (lastActAge != AGE_SAT) begin
      lastActAge <= lastActAge + AGE_ONE;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] actAge;
    logic [CNT_W-1:0] rpAge;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actAge <= '0;
      end else if (strobe.actStart[g]) begin
        actAge <= AGE_ONE;
      end else if (actAge != AGE_SAT) begin
        actAge <= actAge + AGE_ONE;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rpAge <= '0;
      end else if (strobe.preStart[g]) begin
        rpAge <= AGE_ONE;
      end else if (rpAge != AGE_SAT) begin
        rpAge <= rpAge + AGE_ONE;
      end
    end

    assign rcdMet[g]    = actAge >= cfgRcd;
    assign rasMinMet[g] = actAge >= cfgRasMin;
    assign rasMaxNow[g] = actAge == cfgRasMax;
    assign warnNow[g]   = ({1'b0, actAge} + {1'b0, cfgWarnLead}) >= {1'b0, cfgRasMax};
    assign rpMet[g]     = rpAge >= cfgRp;
    assign rrdMet[g]    = !anyAct || (lastActBank == BANK_W'(g)) || (lastActAge >= cfgRrd);
  end

  assign flags = '{rcdMet:    rcdMet,
                   rasMinMet: rasMinMet,
                   rasMaxNow: rasMaxNow,
                   warnNow:   warnNow,
                   rpMet:     rpMet,
                   rrdMet:    rrdMet};
endmodule

// File: rtl/dram_guard_ctrl.sv
module dram_guard_ctrl
  import dram_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  cmd_e                 cmd,
  input  logic [BANK_W-1:0]    cmdBank,
  input  timingFlags_t         flags,
  output bankStrobe_t          strobe,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] bankActive,
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] rwReady,
  output logic [NUM_BANKS-1:0] preReady,
  output logic [NUM_BANKS-1:0] rasWarn,
  output logic [NUM_BANKS-1:0] rasOverdue,
  output logic                 violValid,
  output logic [2:0]           violCode
);
  violCode_e            code;
  logic [NUM_BANKS-1:0] actStartV, preStartV;

  // legality of the command in flight, first failing rule wins
  always_comb begin
    code = VIO_NONE;
    case (cmd)
      CMD_ACT: begin
        if (!bankIdle[cmdBank])      code = VIO_ACT_BUSY;
        else if (!flags.rrdMet[cmdBank]) code = VIO_ACT_RRD;
      end
      CMD_READ, CMD_WRITE: begin
        if (!bankActive[cmdBank])    code = VIO_RW_CLOSED;
        else if (!flags.rcdMet[cmdBank]) code = VIO_RW_RCD;
      end
      CMD_PRE: begin
        if (!bankActive[cmdBank])    code = VIO_PRE_CLOSED;
        else if (!flags.rasMinMet[cmdBank]) code = VIO_PRE_RASMIN;
      end
      default: code = VIO_NONE;
    endcase
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bankState_e state;
    logic       hit;

    assign hit          = (cmdBank == BANK_W'(g)) && (code == VIO_NONE);
    assign actStartV[g] = hit && (cmd == CMD_ACT);
    assign preStartV[g] = hit && (cmd == CMD_PRE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state <= BK_IDLE;
      end else if (actStartV[g]) begin
        state <= BK_ACTIVE;
      end else if (preStartV[g]) begin
        state <= BK_PRECHG;
      end else if (state == BK_PRECHG && flags.rpMet[g]) begin
        state <= BK_IDLE;
      end
    end

    assign bankActive[g] = state == BK_ACTIVE;
    assign bankIdle[g]   = (state == BK_IDLE) || (state == BK_PRECHG && flags.rpMet[g]);
    assign actReady[g]   = bankIdle[g] && flags.rrdMet[g];
    assign rwReady[g]    = bankActive[g] && flags.rcdMet[g];
    assign preReady[g]   = bankActive[g] && flags.rasMinMet[g];
    assign rasWarn[g]    = bankActive[g] && flags.warnNow[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rasOverdue[g] <= 1'b0;
      end else begin
        rasOverdue[g] <= bankActive[g] && flags.rasMaxNow[g] && !preStartV[g];
      end
    end
  end

  assign strobe = '{actStart: actStartV, preStart: preStartV};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violValid <= 1'b0;
      violCode  <= VIO_NONE;
    end else begin
      violValid <= code != VIO_NONE;
      violCode  <= code;
    end
  end
endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard
  import dram_guard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             bankSel,
  input  logic             preSel,
  input  logic [CNT_W-1:0] cfgRcd,
  input  logic [CNT_W-1:0] cfgRrd,
  input  logic [CNT_W-1:0] cfgRasMin,
  input  logic [CNT_W-1:0] cfgRasMax,
  input  logic [CNT_W-1:0] cfgRp,
  input  logic [CNT_W-1:0] cfgWarnLead,
  output logic [1:0]       actReady,
  output logic [1:0]       rwReady,
  output logic [1:0]       preReady,
  output logic [1:0]       bankIdle,
  output logic [1:0]       bankActive,
  output logic [1:0]       rasWarn,
  output logic [1:0]       rasOverdue,
  output logic             violValid,
  output logic [2:0]       violCode
);
  cmd_e         cmd;
  bankStrobe_t  strobe;
  timingFlags_t flags;

  dram_cmd_decode u_decode (
    .csN    (csN),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .preSel (preSel),
    .cmd    (cmd)
  );

  dram_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .cmdBank    (bankSel),
    .flags      (flags),
    .strobe     (strobe),
    .bankIdle   (bankIdle),
    .bankActive (bankActive),
    .actReady   (actReady),
    .rwReady    (rwReady),
    .preReady   (preReady),
    .rasWarn    (rasWarn),
    .rasOverdue (rasOverdue),
    .violValid  (violValid),
    .violCode   (violCode)
  );

  dram_guard_timers #(.CNT_W(CNT_W)) u_timers (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgRcd      (cfgRcd),
    .cfgRrd      (cfgRrd),
    .cfgRasMin   (cfgRasMin),
    .cfgRasMax   (cfgRasMax),
    .cfgRp       (cfgRp),
    .cfgWarnLead (cfgWarnLead),
    .flags       (flags)
  );
endmodule

// File: rtl/dram_bank_guard_chk.sv
module dram_bank_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       bankSel,
  input logic [1:0] rwReady,
  input logic [1:0] bankIdle,
  input logic [1:0] bankActive,
  input logic [1:0] rasWarn,
  input logic [1:0] rasOverdue,
  input logic       violValid,
  input logic [2:0] violCode
);
  logic isAct, isRw;
  assign isAct = !csN && !rasN && casN && weN;
  assign isRw  = !csN && rasN && !casN;

  AST_ACT_OPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (isAct && bankActive[bankSel]) |=> (violValid && violCode == 3'd1)); // R4

  AST_RW_READY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (isRw && rwReady[bankSel]) |=> !violValid); // R2

  AST_VIOL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> $stable(bankActive)); // R9

  AST_WARN_BEFORE_OVERDUE0: assert property (@(posedge clk) disable iff (!rstN)
    rasOverdue[0] |-> $past(rasWarn[0])); // R7

  AST_WARN_BEFORE_OVERDUE1: assert property (@(posedge clk) disable iff (!rstN)
    rasOverdue[1] |-> $past(rasWarn[1])); // R7

  AST_OVERDUE_SINGLE0: assert property (@(posedge clk) disable iff (!rstN)
    rasOverdue[0] |=> !rasOverdue[0]); // R6

  AST_OVERDUE_SINGLE1: assert property (@(posedge clk) disable iff (!rstN)
    rasOverdue[1] |=> !rasOverdue[1]); // R6

  AST_IDLE_ACTIVE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (bankIdle & bankActive) == 2'b00); // R8
endmodule

bind dram_bank_guard dram_bank_guard_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .bankSel    (bankSel),
  .rwReady    (rwReady),
  .bankIdle   (bankIdle),
  .bankActive (bankActive),
  .rasWarn    (rasWarn),
  .rasOverdue (rasOverdue),
  .violValid  (violValid),
  .violCode   (violCode)
);

// File: tb/dram_bank_guard_bench.sv
module dram_bank_guard_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, bankSel = 1'b0, preSel = 1'b0;
  logic [CNT_W-1:0] cfgRcd, cfgRrd, cfgRasMin, cfgRasMax, cfgRp, cfgWarnLead;
  logic [1:0] actReady, rwReady, preReady, bankIdle, bankActive, rasWarn, rasOverdue;
  logic violValid;
  logic [2:0] violCode;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  dram_bank_guard #(.CNT_W(CNT_W)) u_dram_bank_guard (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankSel(bankSel), .preSel(preSel),
    .cfgRcd(cfgRcd), .cfgRrd(cfgRrd), .cfgRasMin(cfgRasMin), .cfgRasMax(cfgRasMax),
    .cfgRp(cfgRp), .cfgWarnLead(cfgWarnLead),
    .actReady(actReady), .rwReady(rwReady), .preReady(preReady),
    .bankIdle(bankIdle), .bankActive(bankActive), .rasWarn(rasWarn),
    .rasOverdue(rasOverdue), .violValid(violValid), .violCode(violCode)
  );

  // bench command numbers: 0 nop, 1 act, 2 read, 3 write, 4 precharge,
  // 5 precharge pattern with preSel low, 6 activate pattern while deselected
  // vector: [9:7] cmd, [6] bank, [5] expected violValid, [4:2] expected code, [1:0] expected bankActive
  localparam logic [9:0] VEC [16] = '{
    {3'd1, 1'b0, 1'b0, 3'd0, 2'b01},
    {3'd1, 1'b1, 1'b1, 3'd2, 2'b01},
    {3'd1, 1'b1, 1'b0, 3'd0, 2'b11},
    {3'd2, 1'b1, 1'b1, 3'd4, 2'b11},
    {3'd2, 1'b0, 1'b0, 3'd0, 2'b11},
    {3'd3, 1'b1, 1'b0, 3'd0, 2'b11},
    {3'd4, 1'b1, 1'b1, 3'd6, 2'b11},
    {3'd4, 1'b1, 1'b0, 3'd0, 2'b01},
    {3'd1, 1'b0, 1'b1, 3'd1, 2'b01},
    {3'd2, 1'b1, 1'b1, 3'd3, 2'b01},
    {3'd1, 1'b1, 1'b0, 3'd0, 2'b11},
    {3'd4, 1'b1, 1'b1, 3'd6, 2'b11},
    {3'd5, 1'b0, 1'b0, 3'd0, 2'b11},
    {3'd6, 1'b1, 1'b0, 3'd0, 2'b11},
    {3'd4, 1'b0, 1'b0, 3'd0, 2'b10},
    {3'd4, 1'b0, 1'b1, 3'd5, 2'b10}
  };

  function automatic string reqOf(input logic [2:0] c);
    case (c)
      3'd1: return "R4";
      3'd2: return "R3";
      3'd3, 3'd4: return "R2";
      3'd5, 3'd6: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCmd(input int c, input logic b);
    csN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; preSel = 1'b0; bankSel = b;
    case (c)
      1: rasN = 1'b0;
      2: casN = 1'b0;
      3: begin casN = 1'b0; weN = 1'b0; end
      4: begin rasN = 1'b0; weN = 1'b0; preSel = 1'b1; end
      5: begin rasN = 1'b0; weN = 1'b0; preSel = 1'b0; end
      6: begin csN = 1'b1; rasN = 1'b0; end
      default: csN = 1'b1;
    endcase
  endtask

  task automatic doReset();
    setCmd(0, 1'b0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failCnt++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    cfgRcd = 8'd3; cfgRrd = 8'd2; cfgRasMin = 8'd5; cfgRasMax = 8'd20;
    cfgRp = 8'd3; cfgWarnLead = 8'd4;
    doReset();

    // R10: reset state
    check(bankIdle == 2'b11, "R10 idle", bankIdle, 3);
    check(bankActive == 2'b00, "R10 active", bankActive, 0);
    check(!violValid, "R10 viol", violValid, 0);
    check(actReady == 2'b11, "R10 actReady", actReady, 3);
    check(rasWarn == 2'b00 && rasOverdue == 2'b00, "R10 warn", {rasWarn, rasOverdue}, 0);

    // table of back-to-back commands
    for (int i = 0; i < 16; i++) begin
      setCmd(int'(VEC[i][9:7]), VEC[i][6]);
      @(negedge clk);
      setCmd(0, 1'b0);
      check(violValid == VEC[i][5], reqOf(VEC[i][4:2]), violValid, VEC[i][5]);
      if (VEC[i][5]) check(violCode == VEC[i][4:2], reqOf(VEC[i][4:2]), violCode, VEC[i][4:2]);
      check(bankActive == VEC[i][1:0], VEC[i][5] ? "R9" : "R1", bankActive, VEC[i][1:0]);
    end

    // directed: open-time window, warnings, ready flags
    cfgRcd = 8'd2; cfgRrd = 8'd3; cfgRasMin = 8'd4; cfgRasMax = 8'd10;
    cfgRp = 8'd5; cfgWarnLead = 8'd3;
    doReset();
    setCmd(1, 1'b0);
    @(negedge clk);
    setCmd(0, 1'b0);
    for (int j = 1; j <= 14; j++) begin
      check(rwReady[0] == (j >= 2), "R2 rwReady", rwReady[0], j >= 2);
      check(preReady[0] == (j >= 4), "R5 preReady", preReady[0], j >= 4);
      check(actReady[1] == (j >= 3), "R3 actReady", actReady[1], j >= 3);
      check(rasWarn[0] == (j >= 7), "R7 rasWarn", rasWarn[0], j >= 7);
      check(rasOverdue[0] == (j == 11), "R6 rasOverdue", rasOverdue[0], j == 11);
      check(rasOverdue[1] == 1'b0, "R6 other bank", rasOverdue[1], 0);
      @(negedge clk);
    end

    // directed: precharge recovery
    setCmd(4, 1'b0);
    @(negedge clk);
    setCmd(0, 1'b0);
    check(!violValid, "R5 late precharge", violValid, 0);
    for (int j = 1; j <= 7; j++) begin
      check(bankIdle[0] == (j >= 5), "R8 bankIdle", bankIdle[0], j >= 5);
      check(actReady[0] == (j >= 5), "R8 actReady", actReady[0], j >= 5);
      check(bankActive[0] == 1'b0 && rasWarn[0] == 1'b0, "R8 closed", {bankActive[0], rasWarn[0]}, 0);
      @(negedge clk);
    end

    finishRun();
  end
endmodule